// File: doc/BRIEF.md
# USB Device Receive Status FIFO

This block is the shared receive queue of a full-speed USB device controller. A packet engine deposits every received event into one word-wide memory as a status word, followed by the packet's payload when there is any. OUT data and SETUP packets carry payload. Global-OUT-NAK, OUT-transfer-complete and setup-stage-done markers carry none. A reader, normally driven by firmware, first takes the status word through a dedicated pop port. The status word holds a byte count, and the reader then drains exactly ceil(count/4) payload words through a second pop port.

Packets are admitted whole or not at all. The engine offers the status fields, and the FIFO accepts them only if the status word and the full payload fit. A level interrupt, gated by an enable input, stays asserted while a complete status word waits at the head of the queue. Each control endpoint has a SETUP budget that allows three back-to-back SETUP packets until it is reloaded. OUT data packets larger than one 64-byte control transfer are refused.

Top module: `usb_rx_stat_fifo`

## Requirements
- R1: A stored status word has this layout: endpoint in bits [3:0], byte count in [14:4], data PID in [16:15] (0=DATA0, 1=DATA1), and packet kind in [20:17]. Bits [31:21] are zero. Kind codes: 1 global OUT NAK, 2 OUT data, 3 OUT transfer complete, 4 setup stage done, 6 SETUP.
- R2: Marker entries are normalised. A global OUT NAK stores zero endpoint, PID and byte count. Transfer-complete and setup-stage-done store the given endpoint, with zero PID and zero byte count.
- R3: A SETUP header is accepted only with a byte count of 8. It is stored with PID DATA0 and is followed by two payload words.
- R4: An accepted packet with byte count N is followed by ceil(N/4) payload words in little-endian byte lanes. Byte lanes past N in the last word read as zero.
- R5: A legal header is refused if the free space is smaller than 1 + ceil(N/4) words. In that case a sticky overflow flag is set and nothing is stored.
- R6: A status word becomes visible only in the cycle after its last payload word is written. An entry without payload becomes visible in the cycle after its header is accepted.
- R7: While an admitted packet still expects payload, new headers are refused. Payload words offered when no payload is expected are ignored.
- R8: When the reader sits at a status word, stat_avail is high and stat_word shows that word. Popping it moves the reader to its payload. After a zero-count entry, the next status word is offered directly.
- R9: A data pop with no payload remaining returns zero, sets a sticky underflow flag and moves nothing.
- R10: irq equals stat_avail gated by irq_en.
- R11: Each control endpoint (number below NUM_EP) starts with a SETUP budget of 3. Each accepted SETUP uses one. A SETUP arriving with the budget at zero is refused. A reload restores 3, and a reload wins over a same-cycle use.
- R12: OUT data headers with a byte count above 64 are refused, as are kind codes not listed in R1.
- R13: After reset the queue is empty, all outputs that depend on the queue are zero, and both flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Engine offers a packet header |
| hdr_kind | input | 4 | Packet kind code |
| hdr_ep | input | 4 | Endpoint number |
| hdr_pid | input | 2 | Data PID |
| hdr_bcnt | input | 11 | Payload byte count |
| hdr_ready | output | 1 | Header would be accepted this cycle |
| pay_valid | input | 1 | Engine offers one payload word |
| pay_data | input | 32 | Payload word, byte 0 in bits [7:0] |
| stat_pop | input | 1 | Reader pops the status word |
| stat_avail | output | 1 | A complete status word is at the head |
| stat_word | output | 32 | Head status word, zero when none |
| data_pop | input | 1 | Reader pops one payload word |
| data_word | output | 32 | Current payload word, zero when none |
| irq_en | input | 1 | Receive interrupt enable |
| irq | output | 1 | Receive-level interrupt |
| setup_reload | input | 1 | Reload a SETUP budget |
| setup_reload_ep | input | 4 | Endpoint whose budget is reloaded |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
hdr_ready, stat_word, data_word, stat_avail and irq follow the current inputs and state in the same cycle. Pointer moves, commits, budgets and the two flags change at the next clock edge, so a status word becomes visible one edge after the last payload word is written. The bench drives inputs just after a rising edge. It compares every output with a queue-based reference model one time step later, before the following edge, and then advances the model for that edge. Directed checks sample in the same window.

// File: rtl/usb_rxf_pkg.sv
package usb_rxf_pkg;

    localparam int KW    = 4;
    localparam int EPW   = 4;
    localparam int PIDW  = 2;
    localparam int BCW   = 11;
    localparam int WORDW = 32;
    localparam int SETUP_BYTES = 8;

    typedef enum logic [KW-1:0] {
        KIND_GNAK       = 4'd1,
        KIND_OUT        = 4'd2,
        KIND_XFER_DONE  = 4'd3,
        KIND_STAGE_DONE = 4'd4,
        KIND_SETUP      = 4'd6
    } rx_kind_e;

    localparam logic [PIDW-1:0] PID_DATA0 = 2'd0;

    typedef struct packed {
        logic [WORDW-KW-PIDW-BCW-EPW-1:0] rsvd;
        logic [KW-1:0]   kind;
        logic [PIDW-1:0] pid;
        logic [BCW-1:0]  bcnt;
        logic [EPW-1:0]  ep;
    } rx_stat_t;

    // number of 32-bit payload words for a byte count
    function automatic logic [BCW-1:0] words_of(input logic [BCW-1:0] nbytes);
        logic [BCW:0] t;
        t = {1'b0, nbytes} + (BCW+1)'(3);
        return BCW'(t >> 2);
    endfunction

    // byte-lane mask for the next payload word given bytes still owed
    function automatic logic [WORDW-1:0] lane_mask(input logic [BCW-1:0] nbytes);
        logic [WORDW-1:0] m;
        case (nbytes)
            BCW'(1): m = 32'h0000_00FF;
            BCW'(2): m = 32'h0000_FFFF;
            BCW'(3): m = 32'h00FF_FFFF;
            default: m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/usb_rxf_store.sv
module usb_rxf_store
    import usb_rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WORDW-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WORDW-1:0] rd_data
);

    logic [WORDW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/usb_rxf_wr_ctl.sv
module usb_rxf_wr_ctl
    import usb_rxf_pkg::*;
#(
    parameter int DEPTH        = 32,
    parameter int NUM_EP       = 4,
    parameter int MAX_PKT      = 64,
    parameter int SETUP_RELOAD = 3,
    localparam int AW  = $clog2(DEPTH),
    localparam int PW  = AW + 1,
    localparam int SCW = $clog2(SETUP_RELOAD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_valid,
    input  logic [KW-1:0]    hdr_kind,
    input  logic [EPW-1:0]   hdr_ep,
    input  logic [PIDW-1:0]  hdr_pid,
    input  logic [BCW-1:0]   hdr_bcnt,
    output logic             hdr_ready,
    input  logic             pay_valid,
    input  logic [WORDW-1:0] pay_data,
    input  logic             setup_reload,
    input  logic [EPW-1:0]   setup_reload_ep,
    input  logic [PW-1:0]    rd_ptr,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WORDW-1:0] wr_word,
    output logic [PW-1:0]    commit_ptr,
    output logic             ovf_flag
);

    logic [PW-1:0]     wr_ptr;
    logic [BCW-1:0]    left_words;
    logic [BCW-1:0]    left_bytes;
    logic [NUM_EP-1:0] cnt_nz;
    logic              setup_ok;
    logic              legal;
    logic              room;
    logic              idle;
    logic              hdr_take;
    logic              pay_take;
    logic              setup_take;
    logic [BCW-1:0]    words;
    logic [PW-1:0]     used;
    rx_stat_t          stat;

    // SETUP budget lookup for the offered endpoint
    always_comb begin
        setup_ok = 1'b0;
        for (int i = 0; i < NUM_EP; i++) begin
            if (hdr_ep == EPW'(i)) setup_ok = cnt_nz[i];
        end
    end

    // header normalisation and legality
    always_comb begin
        stat      = '0;
        stat.kind = hdr_kind;
        legal     = 1'b0;
        case (hdr_kind)
            KIND_GNAK: legal = 1'b1;
            KIND_OUT: begin
                stat.ep   = hdr_ep;
                stat.pid  = hdr_pid;
                stat.bcnt = hdr_bcnt;
                legal     = (hdr_bcnt <= BCW'(MAX_PKT));
            end
            KIND_XFER_DONE, KIND_STAGE_DONE: begin
                stat.ep = hdr_ep;
                legal   = 1'b1;
            end
            KIND_SETUP: begin
                stat.ep   = hdr_ep;
                stat.pid  = PID_DATA0;
                stat.bcnt = BCW'(SETUP_BYTES);
                legal     = (hdr_bcnt == BCW'(SETUP_BYTES)) && setup_ok;
            end
            default: legal = 1'b0;
        endcase
        words = words_of(stat.bcnt);
    end

    assign used       = wr_ptr - rd_ptr;
    assign room       = (int'(used) + 1 + int'(words)) <= DEPTH;
    assign idle       = (left_words == '0);
    assign hdr_ready  = idle && legal && room;
    assign hdr_take   = hdr_valid && hdr_ready;
    assign pay_take   = pay_valid && !idle;
    assign setup_take = hdr_take && (hdr_kind == KIND_SETUP);

    assign wr_en   = hdr_take || pay_take;
    assign wr_addr = wr_ptr[AW-1:0];
    assign wr_word = hdr_take ? WORDW'(stat) : (pay_data & lane_mask(left_bytes));

    for (genvar i = 0; i < NUM_EP; i++) begin : g_setup_cnt
        logic [SCW-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst)
                cnt <= SCW'(SETUP_RELOAD);
            else if (setup_reload && setup_reload_ep == EPW'(i))
                cnt <= SCW'(SETUP_RELOAD);
            else if (setup_take && hdr_ep == EPW'(i))
                cnt <= cnt - 1'b1;
        end
        assign cnt_nz[i] = (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            commit_ptr <= '0;
            left_words <= '0;
            left_bytes <= '0;
            ovf_flag   <= 1'b0;
        end else begin
            if (hdr_valid && idle && legal && !room) ovf_flag <= 1'b1;
            if (hdr_take) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (words == '0) begin
                    commit_ptr <= wr_ptr + 1'b1;
                end else begin
                    left_words <= words;
                    left_bytes <= stat.bcnt;
                end
            end else if (pay_take) begin
                wr_ptr     <= wr_ptr + 1'b1;
                left_words <= left_words - 1'b1;
                left_bytes <= (left_bytes >= BCW'(4)) ? left_bytes - BCW'(4) : '0;
                if (left_words == BCW'(1)) commit_ptr <= wr_ptr + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(used) <= DEPTH); // R5
    AST_PARTIAL_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (left_words != '0 && !(pay_valid && left_words == BCW'(1))) |=> $stable(commit_ptr)); // R6

endmodule

// File: rtl/usb_rxf_rd_ctl.sv
module usb_rxf_rd_ctl
    import usb_rxf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PW-1:0]    commit_ptr,
    input  logic [WORDW-1:0] head_word,
    input  logic             stat_pop,
    input  logic             data_pop,
    output logic [PW-1:0]    rd_ptr,
    output logic             stat_avail,
    output logic [WORDW-1:0] stat_word,
    output logic [WORDW-1:0] data_word,
    output logic             udf_flag
);

    logic [BCW-1:0] left;
    rx_stat_t       head;

    assign head       = rx_stat_t'(head_word);
    assign stat_avail = (left == '0) && (rd_ptr != commit_ptr);
    assign stat_word  = stat_avail ? head_word : '0;
    assign data_word  = (left != '0) ? head_word : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr   <= '0;
            left     <= '0;
            udf_flag <= 1'b0;
        end else begin
            if (data_pop && left == '0) udf_flag <= 1'b1;
            if (stat_pop && stat_avail) begin
                rd_ptr <= rd_ptr + 1'b1;
                left   <= words_of(head.bcnt);
            end else if (data_pop && left != '0) begin
                rd_ptr <= rd_ptr + 1'b1;
                left   <= left - 1'b1;
            end
        end
    end

    AST_PAYLOAD_COMMITTED: assert property (@(posedge clk) disable iff (rst)
        (left != '0) |-> (int'(PW'(commit_ptr - rd_ptr)) >= int'(left))); // R8
    AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (data_pop && left == '0 && !stat_pop) |=> $stable(rd_ptr)); // R9

endmodule

// File: rtl/usb_rx_stat_fifo.sv
module usb_rx_stat_fifo
    import usb_rxf_pkg::*;
#(
    parameter int DEPTH        = 32,
    parameter int NUM_EP       = 4,
    parameter int MAX_PKT      = 64,
    parameter int SETUP_RELOAD = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hdr_valid,
    input  logic [3:0]  hdr_kind,
    input  logic [3:0]  hdr_ep,
    input  logic [1:0]  hdr_pid,
    input  logic [10:0] hdr_bcnt,
    output logic        hdr_ready,
    input  logic        pay_valid,
    input  logic [31:0] pay_data,
    input  logic        stat_pop,
    output logic        stat_avail,
    output logic [31:0] stat_word,
    input  logic        data_pop,
    output logic [31:0] data_word,
    input  logic        irq_en,
    output logic        irq,
    input  logic        setup_reload,
    input  logic [3:0]  setup_reload_ep,
    output logic        ovf_flag,
    output logic        udf_flag
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [WORDW-1:0] wr_word;
    logic [PW-1:0]    commit_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [WORDW-1:0] head_word;
    rx_stat_t         stat_view;

    usb_rxf_wr_ctl #(
        .DEPTH(DEPTH), .NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT), .SETUP_RELOAD(SETUP_RELOAD)
    ) u_wr (
        .clk(clk), .rst(rst),
        .hdr_valid(hdr_valid), .hdr_kind(hdr_kind), .hdr_ep(hdr_ep),
        .hdr_pid(hdr_pid), .hdr_bcnt(hdr_bcnt), .hdr_ready(hdr_ready),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .setup_reload(setup_reload), .setup_reload_ep(setup_reload_ep),
        .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
        .commit_ptr(commit_ptr), .ovf_flag(ovf_flag)
    );

    usb_rxf_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_word),
        .rd_addr(rd_ptr[AW-1:0]), .rd_data(head_word)
    );

    usb_rxf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst(rst), .commit_ptr(commit_ptr), .head_word(head_word),
        .stat_pop(stat_pop), .data_pop(data_pop), .rd_ptr(rd_ptr),
        .stat_avail(stat_avail), .stat_word(stat_word), .data_word(data_word),
        .udf_flag(udf_flag)
    );

    assign irq       = stat_avail && irq_en;
    assign stat_view = rx_stat_t'(stat_word);

    AST_IRQ_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_view.kind != '0)); // R10

endmodule

// File: tb/sim_usb_rx_stat_fifo.sv
module sim_usb_rx_stat_fifo;

    localparam int DEPTH = 32;
    localparam int NEP   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hdr_valid = 0, pay_valid = 0, stat_pop = 0, data_pop = 0;
    logic        irq_en = 0, setup_reload = 0;
    logic [3:0]  hdr_kind = 0, hdr_ep = 0, setup_reload_ep = 0;
    logic [1:0]  hdr_pid = 0;
    logic [10:0] hdr_bcnt = 0;
    logic [31:0] pay_data = 0;
    logic        hdr_ready, stat_avail, irq, ovf_flag, udf_flag;
    logic [31:0] stat_word, data_word;

    always #10 clk = ~clk;

    usb_rx_stat_fifo u0 (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_kind(hdr_kind),
        .hdr_ep(hdr_ep), .hdr_pid(hdr_pid), .hdr_bcnt(hdr_bcnt), .hdr_ready(hdr_ready),
        .pay_valid(pay_valid), .pay_data(pay_data), .stat_pop(stat_pop),
        .stat_avail(stat_avail), .stat_word(stat_word), .data_pop(data_pop),
        .data_word(data_word), .irq_en(irq_en), .irq(irq),
        .setup_reload(setup_reload), .setup_reload_ep(setup_reload_ep),
        .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [31:0] q[$];
    logic [31:0] pend[$];
    int m_left = 0, w_left = 0, w_bytes = 0;
    int sc[NEP];
    bit m_ovf = 0, m_udf = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_eval(output bit rdy, output bit ovfc,
                                   output logic [31:0] sw, output int nw);
        int k = int'(hdr_kind);
        int e = int'(hdr_ep);
        int b = int'(hdr_bcnt);
        bit ok = 0;
        bit room;
        sw = 0; nw = 0;
        case (k)
            1: begin ok = 1; sw = 32'(k) << 17; end
            2: begin
                ok = (b <= 64);
                sw = (32'(k) << 17) | (32'(hdr_pid) << 15) | (32'(b) << 4) | 32'(e);
                nw = (b + 3) / 4;
            end
            3, 4: begin ok = 1; sw = (32'(k) << 17) | 32'(e); end
            6: begin
                ok = (b == 8) && (e < NEP) && (sc[e] > 0);
                sw = (32'(k) << 17) | (32'd8 << 4) | 32'(e);
                nw = 2;
            end
            default: ok = 0;
        endcase
        room = (q.size() + pend.size() + 1 + nw) <= DEPTH;
        rdy  = (w_left == 0) && ok && room;
        ovfc = hdr_valid && (w_left == 0) && ok && !room;
    endfunction

    task automatic m_reset();
        q.delete(); pend.delete();
        m_left = 0; w_left = 0; w_bytes = 0; m_ovf = 0; m_udf = 0;
        for (int i = 0; i < NEP; i++) sc[i] = 3;
    endtask

    task automatic cyc();
        bit rdy, ovfc, av;
        logic [31:0] sw;
        int nw;
        #1;
        if (rst) begin
            m_reset();
        end else begin
            m_eval(rdy, ovfc, sw, nw);
            av = (m_left == 0) && (q.size() > 0);
            chk("R8 stat_avail", 32'(stat_avail), 32'(av));
            chk("R1 stat_word", stat_word, av ? q[0] : 32'h0);
            chk("R4 data_word", data_word, (m_left > 0) ? q[0] : 32'h0);
            chk("R10 irq", 32'(irq), 32'(av && irq_en));
            chk("R12 hdr_ready", 32'(hdr_ready), 32'(rdy));
            chk("R5 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            chk("R9 udf_flag", 32'(udf_flag), 32'(m_udf));
            // read side of the coming edge
            if (data_pop) begin
                if (m_left > 0) begin void'(q.pop_front()); m_left--; end
                else m_udf = 1;
            end
            if (stat_pop && av) begin
                logic [31:0] w;
                w = q.pop_front();
                m_left = (int'(w[14:4]) + 3) / 4;
            end
            // write side
            if (ovfc) m_ovf = 1;
            if (hdr_valid && rdy) begin
                if (hdr_kind == 4'd6) sc[int'(hdr_ep)]--;
                if (nw == 0) q.push_back(sw);
                else begin pend.push_back(sw); w_left = nw; w_bytes = int'(sw[14:4]); end
            end else if (pay_valid && w_left > 0) begin
                logic [31:0] d;
                d = (w_bytes >= 4) ? pay_data : (pay_data & ((32'h1 << (8 * w_bytes)) - 1));
                pend.push_back(d);
                w_bytes = (w_bytes >= 4) ? w_bytes - 4 : 0;
                w_left--;
                if (w_left == 0) begin
                    foreach (pend[i]) q.push_back(pend[i]);
                    pend.delete();
                end
            end
            if (setup_reload && int'(setup_reload_ep) < NEP) sc[int'(setup_reload_ep)] = 3;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic send_hdr(int k, int e, int p, int b);
        hdr_kind = 4'(k); hdr_ep = 4'(e); hdr_pid = 2'(p); hdr_bcnt = 11'(b);
        hdr_valid = 1; cyc(); hdr_valid = 0;
    endtask

    task automatic send_pay(logic [31:0] d);
        pay_valid = 1; pay_data = d; cyc(); pay_valid = 0;
    endtask

    task automatic pop_stat();
        stat_pop = 1; cyc(); stat_pop = 0;
    endtask

    task automatic pop_data();
        data_pop = 1; cyc(); data_pop = 0;
    endtask

    task automatic drain();
        while (q.size() > 0 || m_left > 0) begin
            if (m_left > 0) pop_data(); else pop_stat();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) cyc();
        rst = 0;
        #1;
        chk("R13 reset stat_avail", 32'(stat_avail), 0);
        chk("R13 reset stat_word", stat_word, 0);
        chk("R13 reset data_word", data_word, 0);
        chk("R13 reset flags", {30'b0, ovf_flag, udf_flag}, 0);
        irq_en = 1;

        // OUT data, 5 bytes, endpoint 1, DATA1
        send_hdr(2, 1, 1, 5);
        send_pay(32'hAABBCCDD);
        #1 chk("R6 hidden until last word", 32'(stat_avail), 0);
        send_pay(32'h11223344);
        #1 chk("R1 OUT status layout", stat_word, 32'h0004_8051);
        chk("R10 irq with entry", 32'(irq), 1);
        pop_stat();
        #1 chk("R4 first payload word", data_word, 32'hAABBCCDD);
        pop_data();
        #1 chk("R4 masked last word", data_word, 32'h0000_0044);
        pop_data();
        pop_data();
        #1 chk("R9 underflow flag", 32'(udf_flag), 1);
        chk("R9 underflow returns zero", data_word, 0);

        // markers
        send_hdr(1, 7, 3, 100);
        #1 chk("R2 global NAK normalised", stat_word, 32'h0002_0000);
        pop_stat();
        send_hdr(4, 2, 3, 9);
        send_hdr(3, 3, 1, 0);
        #1 chk("R2 stage done normalised", stat_word, 32'h0008_0002);
        pop_stat();
        #1 chk("R8 next status after zero count", stat_word, 32'h0006_0003);
        pop_stat();

        // SETUP handling
        send_hdr(6, 0, 2, 8);
        send_pay(32'h0102_0304);
        send_pay(32'h0506_0708);
        #1 chk("R3 SETUP forced DATA0", stat_word, 32'h000C_0080);
        drain();
        hdr_kind = 4'd6; hdr_ep = 0; hdr_bcnt = 11'd7; hdr_valid = 1;
        #1 chk("R3 SETUP with count 7 refused", 32'(hdr_ready), 0);
        cyc(); hdr_valid = 0;
        for (int i = 0; i < 2; i++) begin
            send_hdr(6, 0, 0, 8);
            send_pay(32'h1111_0000 + 32'(i));
            send_pay(32'h2222_0000 + 32'(i));
        end
        hdr_kind = 4'd6; hdr_ep = 0; hdr_bcnt = 11'd8; hdr_valid = 1;
        #1 chk("R11 fourth SETUP refused", 32'(hdr_ready), 0);
        cyc(); hdr_valid = 0;
        setup_reload = 1; setup_reload_ep = 0; cyc(); setup_reload = 0;
        hdr_valid = 1;
        #1 chk("R11 reload restores budget", 32'(hdr_ready), 1);
        cyc(); hdr_valid = 0;
        send_pay(32'h3); send_pay(32'h4);
        drain();

        // size limits and unknown codes
        hdr_kind = 4'd2; hdr_ep = 2; hdr_bcnt = 11'd65; hdr_valid = 1;
        #1 chk("R12 OUT above 64 refused", 32'(hdr_ready), 0);
        hdr_kind = 4'd5; hdr_bcnt = 11'd0;
        #1 chk("R12 unknown kind refused", 32'(hdr_ready), 0);
        hdr_valid = 0; cyc();
        send_hdr(2, 2, 0, 64);
        for (int i = 0; i < 16; i++) send_pay(32'(i) * 32'h0101_0101);
        hdr_kind = 4'd2; hdr_ep = 2; hdr_bcnt = 11'd64; hdr_valid = 1;
        #1 chk("R5 no room refused", 32'(hdr_ready), 0);
        cyc(); hdr_valid = 0;
        #1 chk("R5 overflow flag set", 32'(ovf_flag), 1);
        drain();
        #1 chk("R5 nothing stored", 32'(stat_avail), 0);

        // header during payload, stray payload
        send_hdr(2, 5, 0, 4);
        hdr_kind = 4'd1; hdr_valid = 1;
        #1 chk("R7 header refused mid packet", 32'(hdr_ready), 0);
        cyc(); hdr_valid = 0;
        send_pay(32'hCAFE_F00D);
        send_pay(32'hDEAD_BEEF);
        irq_en = 0;
        #1 chk("R10 irq masked", 32'(irq), 0);
        irq_en = 1;
        chk("R7 status after refusal", stat_word, 32'h0004_0045);
        drain();
        #1 chk("R7 stray payload ignored", 32'(stat_avail), 0);

        // zero-length OUT data
        send_hdr(2, 1, 0, 0);
        pop_stat();
        #1 chk("R8 zero count has no payload", data_word, 0);

        // random traffic against the model
        for (int i = 0; i < 1500; i++) begin
            hdr_valid = ($urandom % 3) == 0;
            hdr_kind = 4'($urandom % 8);
            hdr_ep = 4'($urandom % 6);
            hdr_pid = 2'($urandom);
            hdr_bcnt = 11'($urandom % 72);
            pay_valid = ($urandom % 3) != 0;
            pay_data = $urandom;
            stat_pop = ($urandom % 3) == 0;
            data_pop = ($urandom % 2) == 0;
            irq_en = ($urandom % 4) != 0;
            setup_reload = ($urandom % 8) == 0;
            setup_reload_ep = 4'($urandom % 5);
            cyc();
        end
        hdr_valid = 0; pay_valid = 0; stat_pop = 0; data_pop = 0; setup_reload = 0;
        repeat (4) cyc();

        summary();
        $finish;
    end

endmodule